// File: doc/BRIEF.md
# PLL Clock-Source Controller

This block is the software-facing control point for a clock generator built around an analog PLL. It holds three software bits: a PLL enable, a base-clock select and a PLL interrupt enable. It also holds a sticky PLL event flag and shows the synchronized lock state of the PLL. The analog loop appears only as a lock input and a free-running VCO clock input.

From the base-clock select the block builds its output clock. The output is either the reference (crystal) clock or the VCO clock divided down. A glitch-free two-branch switch makes the change-over. Nothing stops software from selecting the VCO path before lock: the output then runs from an unlocked VCO.

A stop request turns the VCO off, and a separate input decides whether the reference oscillator keeps running in stop. A wait request leaves everything as it was. While a debug break is active, software accesses leave the event flag alone, unless a break clear-enable input allows them to clear it.

Top module: `pllctl_top`

## Requirements
- R1: After reset, `rdata` reads 0, `pll_on` and `irq` are 0, `xtal_keep` is 1, and `clk_out` follows `ref_clk`.
- R2: The field layout of `rdata` and `wdata` is: bit 0 interrupt enable, bit 1 event flag, bit 2 lock, bit 3 PLL enable, bit 4 base select; higher bits read 0. With base select 1, `clk_out` runs at the `vco_clk` rate divided by `VCO_DIV` (default 2). With base select 0, `clk_out` runs at the `ref_clk` rate.
- R3: Across a source change `clk_out` shows no high or low phase shorter than the shorter half-period of the two sources, and the two source enables are never both active.
- R4: A write takes effect at the next `ref_clk` edge, whatever the lock state. This includes setting base select while lock reads 0.
- R5: `pll_on` equals the PLL enable bit except while `stop_req` is 1, when it is 0. In stop the divided VCO clock halts, so a `clk_out` running on the VCO path stops toggling, and it resumes after stop ends.
- R6: `xtal_keep` is 0 only when `stop_req` is 1 and `stop_clk_en` is 0.
- R7: `wait_req` has no effect on `rdata`, `pll_on` or the frequency of `clk_out`.
- R8: `lock_in` passes through a two-stage synchronizer. A change shows in the lock bit after the second `ref_clk` rising edge, and not after the first.
- R9: Every change of the lock bit, up or down, sets the event flag one `ref_clk` edge later. `irq` equals the flag ANDed with the interrupt enable.
- R10: A write with bit 1 set clears the flag, and a write with bit 1 at 0 leaves it. A flag set in the same cycle as a clearing write wins, and the flag stays 1.
- R11: While `brk_active` is 1 and `brk_clr_en` is 0, writes leave the flag unchanged. The other writable bits still update.
- R12: While `brk_active` is 1 and `brk_clr_en` is 1, a clearing write clears the flag. The flag stays 0 after `brk_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register |
| vco_clk | input | 1 | Raw VCO clock from the analog PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | REG_W | Register write data |
| rdata | output | REG_W | Register read data |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| stop_req | input | 1 | Stop-mode request |
| wait_req | input | 1 | Wait-mode request (no effect) |
| stop_clk_en | input | 1 | Keep reference oscillator running in stop |
| brk_active | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allow flag clearing during break |
| pll_on | output | 1 | Enable to the analog PLL / VCO |
| xtal_keep | output | 1 | Enable to the reference oscillator |
| irq | output | 1 | PLL interrupt request |
| clk_out | output | 1 | Selected base clock |

## Verification
Most internal faults reach `rdata` within one to three `ref_clk` edges. A bad synchronizer depth moves the cycle in which the lock bit changes. A wrong flag priority or a leaky break gate leaves the wrong flag value right after the write. Faults in the clock switch or the divider show only at `clk_out`. They appear as a wrong edge count in a 40-cycle window, as a short phase seen during a change-over, or as an output that keeps running when stop should freeze it. The checks therefore sample `rdata` in fixed cycles after each stimulus and count `clk_out` edges over fixed windows.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
   // register field positions (software-visible layout)
   localparam int unsigned F_IRQEN = 0;
   localparam int unsigned F_FLAG  = 1;
   localparam int unsigned F_LOCK  = 2;
   localparam int unsigned F_PLLEN = 3;
   localparam int unsigned F_BASE  = 4;
   localparam int unsigned F_COUNT = 5;

   typedef struct packed {
      logic base_sel;
      logic pll_en;
      logic irq_en;
   } ctrl_t;
endpackage

// File: rtl/pllctl_sync.sv
module pllctl_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pllctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= RST_VAL;
         end else if (i == 0) begin
            chain[i] <= d;
         end else begin
            chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pllctl_regs.sv
module pllctl_regs
   import pllctl_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             lock_s,
   input  logic             brk_active,
   input  logic             brk_clr_en,
   output ctrl_t            ctrl,
   output logic             flag
);
   if (REG_W < F_COUNT) begin : g_bad_width
      $error("pllctl_regs: REG_W too narrow for the field layout");
   end

   logic lock_q;
   logic lock_edge;
   logic clr_allowed;
   logic clr_req;
   logic flag_d;

   // only the low fields are decoded
   if (REG_W > F_COUNT) begin : g_hi
      logic unused_hi_bits;
      assign unused_hi_bits = ^wdata[REG_W-1:F_COUNT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock_s;
   end

   assign lock_edge   = lock_s ^ lock_q;
   assign clr_allowed = !brk_active || brk_clr_en;
   assign clr_req     = wr_en && wdata[F_FLAG] && clr_allowed;

   always_comb begin
      flag_d = flag;
      if (clr_req)   flag_d = 1'b0;
      if (lock_edge) flag_d = 1'b1;   // event wins over clear
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         ctrl <= '0;
      end else begin
         flag <= flag_d;
         if (wr_en) begin
            ctrl.base_sel <= wdata[F_BASE];
            ctrl.pll_en   <= wdata[F_PLLEN];
            ctrl.irq_en   <= wdata[F_IRQEN];
         end
      end
   end
endmodule

// File: rtl/pllctl_clksw.sv
module pllctl_clksw #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VCO_DIV     = 2
) (
   input  logic ref_clk,
   input  logic vco_clk,
   input  logic rst_n,
   input  logic base_sel,
   input  logic pll_on,
   output logic clk_out
);
   if (VCO_DIV < 2 || (VCO_DIV % 2) != 0) begin : g_bad_div
      $error("pllctl_clksw: VCO_DIV must be even and at least 2");
   end

   localparam int unsigned HALF = VCO_DIV / 2;

   logic run_v;
   logic vdiv;
   logic ref_req, ref_en;
   logic vco_req, vco_en;
   logic want_ref, want_vco;

   // run enable carried into the VCO domain
   pllctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
      .clk(vco_clk), .rst_n(rst_n), .d(pll_on), .q(run_v)
   );

   // divider variant picked by ratio
   if (HALF == 1) begin : g_div_toggle
      always_ff @(posedge vco_clk or negedge rst_n) begin
         if (!rst_n)     vdiv <= 1'b0;
         else if (run_v) vdiv <= ~vdiv;
      end
   end else begin : g_div_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge vco_clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt  <= '0;
            vdiv <= 1'b0;
         end else if (run_v) begin
            if (cnt == CW'(HALF - 1)) begin
               cnt  <= '0;
               vdiv <= ~vdiv;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // reference branch
   assign want_ref = !base_sel && !vco_en;

   pllctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ref_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(want_ref), .q(ref_req)
   );

   always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) ref_en <= 1'b1;
      else        ref_en <= ref_req;
   end

   // divided-VCO branch
   assign want_vco = base_sel && !ref_en;

   pllctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vco_sync (
      .clk(vdiv), .rst_n(rst_n), .d(want_vco), .q(vco_req)
   );

   always_ff @(negedge vdiv or negedge rst_n) begin
      if (!rst_n) vco_en <= 1'b0;
      else        vco_en <= vco_req;
   end

   assign clk_out = (ref_clk & ref_en) | (vdiv & vco_en);
endmodule

// File: rtl/pllctl_top.sv
module pllctl_top
   import pllctl_pkg::*;
#(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VCO_DIV     = 2
) (
   input  logic             ref_clk,
   input  logic             vco_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             lock_in,
   input  logic             stop_req,
   input  logic             wait_req,
   input  logic             stop_clk_en,
   input  logic             brk_active,
   input  logic             brk_clr_en,
   output logic             pll_on,
   output logic             xtal_keep,
   output logic             irq,
   output logic             clk_out
);
   ctrl_t ctrl;
   logic  flag;
   logic  lock_s;
   logic  wait_unused;

   // wait mode leaves this block untouched
   assign wait_unused = wait_req;

   pllctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(lock_in), .q(lock_s)
   );

   pllctl_regs #(.REG_W(REG_W)) u_regs (
      .clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
      .lock_s(lock_s), .brk_active(brk_active), .brk_clr_en(brk_clr_en),
      .ctrl(ctrl), .flag(flag)
   );

   assign pll_on    = ctrl.pll_en && !stop_req;
   assign xtal_keep = !stop_req || stop_clk_en;
   assign irq       = flag && ctrl.irq_en;

   pllctl_clksw #(.SYNC_STAGES(SYNC_STAGES), .VCO_DIV(VCO_DIV)) u_clksw (
      .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
      .base_sel(ctrl.base_sel), .pll_on(pll_on), .clk_out(clk_out)
   );

   always_comb begin
      rdata          = '0;
      rdata[F_IRQEN] = ctrl.irq_en;
      rdata[F_FLAG]  = flag;
      rdata[F_LOCK]  = lock_s;
      rdata[F_PLLEN] = ctrl.pll_en;
      rdata[F_BASE]  = ctrl.base_sel;
   end
endmodule

// File: rtl/pllctl_chk.sv
module pllctl_chk
   import pllctl_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input logic             ref_clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wdata,
   input logic [REG_W-1:0] rdata,
   input logic             stop_req,
   input logic             pll_on,
   input logic             brk_active,
   input logic             brk_clr_en,
   input logic             ref_en,
   input logic             vco_en
);
   // R3: never both source branches enabled
   p_excl_src_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $onehot0({ref_en, vco_en}));

   // R4: a base-select write lands next edge regardless of lock
   p_sel_accept_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      wr_en |=> (rdata[F_BASE] == $past(wdata[F_BASE])));

   // R5: stop keeps the VCO off
   p_stop_off_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      stop_req |-> !pll_on);

   // R9: any lock bit change raises the flag one edge later
   p_lock_flag_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !$stable(rdata[F_LOCK]) |=> rdata[F_FLAG]);

   // R11: flag protected while in break without clear permission
   p_brk_hold_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (brk_active && !brk_clr_en && rdata[F_FLAG]) |=> rdata[F_FLAG]);
endmodule

bind pllctl_top pllctl_chk #(.REG_W(REG_W)) i_chk (
   .ref_clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
   .rdata(rdata), .stop_req(stop_req), .pll_on(pll_on),
   .brk_active(brk_active), .brk_clr_en(brk_clr_en),
   .ref_en(u_clksw.ref_en), .vco_en(u_clksw.vco_en)
);

// File: tb/test_pllctl_top.sv
`timescale 1ns/1ps
module test_pllctl_top;
   logic       ref_clk = 1'b0;
   logic       vco_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       lock_in = 1'b0, stop_req = 1'b0, wait_req = 1'b0;
   logic       stop_clk_en = 1'b0, brk_active = 1'b0, brk_clr_en = 1'b0;
   logic       pll_on, xtal_keep, irq, clk_out;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;
   int  edge_cnt = 0;
   real last_t = -1.0;
   real min_ph = 1.0e9;

   always #10 ref_clk = ~ref_clk;   // 50 MHz
   always #3  vco_clk = ~vco_clk;   // divided by 2 -> 12 ns

   pllctl_top i_pllctl_top (
      .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .lock_in(lock_in), .stop_req(stop_req),
      .wait_req(wait_req), .stop_clk_en(stop_clk_en), .brk_active(brk_active),
      .brk_clr_en(brk_clr_en), .pll_on(pll_on), .xtal_keep(xtal_keep),
      .irq(irq), .clk_out(clk_out)
   );

   always @(posedge clk_out) edge_cnt++;
   always @(clk_out) begin
      if (last_t >= 0.0 && ($realtime - last_t) < min_ph) min_ph = $realtime - last_t;
      last_t = $realtime;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge ref_clk);
      wr_en = 1'b1; wdata = v;
      @(negedge ref_clk);
      wr_en = 1'b0;
   endtask

   task automatic window(output int n);
      int c0;
      c0 = edge_cnt;
      cyc(40);
      n = edge_cnt - c0;
   endtask

   task automatic toggle_lock();
      lock_in = ~lock_in;
      cyc(5);
   endtask

   initial begin
      int n;
      logic [7:0] snap, expv;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      chk(rdata == 8'h00, "R1 rdata", rdata, 0);
      chk(pll_on == 1'b0 && irq == 1'b0, "R1 pll_on/irq", {pll_on, irq}, 0);
      chk(xtal_keep == 1'b1, "R1 xtal_keep", xtal_keep, 1);
      window(n);
      chk(n == 40, "R1 clk_out on ref", n, 40);

      // R4/R2: switch to VCO while lock is 0
      min_ph = 1.0e9;
      wr(8'h08);
      chk(rdata[3] == 1'b1 && pll_on, "R5 pll_on follows enable", pll_on, 1);
      wr(8'h18);
      chk(rdata[4] == 1'b1 && rdata[2] == 1'b0, "R4 base select while unlocked", rdata, 8'h18);
      cyc(20);
      window(n);
      chk(n >= 65 && n <= 68, "R2 clk_out on vco/2", n, 67);

      // R7: wait has no effect
      snap = rdata;
      wait_req = 1'b1;
      window(n);
      chk(n >= 65 && n <= 68, "R7 clock during wait", n, 67);
      chk(rdata == snap && pll_on, "R7 state during wait", rdata, snap);
      wait_req = 1'b0;

      // R5: stop freezes the VCO-derived output
      stop_req = 1'b1;
      cyc(1);
      chk(pll_on == 1'b0, "R5 stop forces pll_on low", pll_on, 0);
      cyc(10);
      window(n);
      chk(n == 0, "R5 no vco clock in stop", n, 0);
      stop_req = 1'b0;
      cyc(10);
      window(n);
      chk(n >= 65 && n <= 68, "R5 vco clock resumes", n, 67);

      // back to reference
      wr(8'h08);
      cyc(20);
      window(n);
      chk(n == 40, "R2 clk_out back on ref", n, 40);
      chk(min_ph > 5.9, "R3 shortest phase (ps)", longint'(min_ph * 1000.0), 6000);

      // R6/R5 sweep of stop inputs
      for (int c = 0; c < 8; c++) begin
         wr((c & 1) ? 8'h08 : 8'h00);
         stop_req = c[1]; stop_clk_en = c[2];
         #1;
         chk(pll_on == (c[0] && !c[1]), "R5 pll_on sweep", pll_on, (c[0] && !c[1]));
         chk(xtal_keep == (!c[1] || c[2]), "R6 xtal_keep sweep", xtal_keep, (!c[1] || c[2]));
         stop_req = 1'b0; stop_clk_en = 1'b0;
      end

      // R10/R4/R9 write sweep with the flag set beforehand
      for (int v = 0; v < 32; v++) begin
         toggle_lock();
         wr(8'(v));
         expv = {3'b000, v[4], v[3], lock_in, ~v[1], v[0]};
         chk(rdata == expv, "R10 write sweep", rdata, expv);
         chk(irq == (v[0] && !v[1]), "R9 irq sweep", irq, (v[0] && !v[1]));
      end

      // R8/R9 exact lock timing
      lock_in = 1'b0;
      cyc(5);
      wr(8'h03);                 // irq enable, clear flag
      chk(rdata == 8'h01, "R10 clear", rdata, 8'h01);
      lock_in = 1'b1;
      cyc(1);
      chk(rdata[2] == 1'b0, "R8 lock after one edge", rdata[2], 0);
      cyc(1);
      chk(rdata[2] == 1'b1 && rdata[1] == 1'b0, "R8 lock after two edges", rdata, 8'h05);
      cyc(1);
      chk(rdata[1] == 1'b1 && irq == 1'b1, "R9 flag and irq", {rdata[1], irq}, 3);
      wr(8'h03);
      lock_in = 1'b0;
      cyc(3);
      chk(rdata[1] == 1'b1, "R9 flag on falling lock", rdata[1], 1);

      // R10 set wins over simultaneous clear
      wr(8'h03);
      lock_in = 1'b1;
      @(negedge ref_clk);
      wr(8'h03);
      chk(rdata[1] == 1'b1, "R10 set beats clear", rdata[1], 1);

      // R11 break without clear permission
      brk_active = 1'b1; brk_clr_en = 1'b0;
      wr(8'h0A);
      chk(rdata[1] == 1'b1 && rdata[3] == 1'b1 && rdata[0] == 1'b0,
          "R11 flag held, others written", rdata, 8'h0E);
      // R12 break with clear permission
      brk_clr_en = 1'b1;
      wr(8'h02);
      chk(rdata[1] == 1'b0, "R12 cleared in break", rdata[1], 0);
      brk_active = 1'b0; brk_clr_en = 1'b0;
      cyc(3);
      chk(rdata[1] == 1'b0, "R12 stays cleared", rdata[1], 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule